// File: doc/BRIEF.md
# Register-Mapped Eight-Pin GPIO Expander Core

This core gives a host eight general-purpose pins behind a small byte-wide register bus. Each pin can be set up as an input or as an output. An output can drive high or low, or it can be left floating through a separate tri-state mask. An input pin can have a pull resistor switched on, and the pull can go either up or down. The bus has an address, write data, a write strobe, a read strobe and registered read data. The serial front end that produces these strobes sits outside the core, and so do the analog pad cells. The pads appear here as output-enable, output-value and pull-control vectors, plus a raw input vector.

Each input is first synchronized. It is then compared with a programmable expected level. When an unmasked pin differs from its expected level, a sticky status bit is set, and an active-low interrupt line stays asserted while any status bit is set. Reading the status register clears it. An identification register reports a fixed vendor code and a revision, together with a flag that shows a reset has occurred. Writing a 1 to bit 0 of the same register resets the core from software.

Top module: `gpio_expander_core`

## Requirements
- R1: After reset, direction reads 0x00, output level 0x00, tri-state 0xFF, expected level 0xFF, pull enable 0xFF, pull polarity 0xFF (pull-up) and interrupt mask 0xFF. The reset-occurred flag is 1 and the status register is 0x00.
- R2: Address 0x01 reads {3'b101, REV_ID[2:0], reset_flag, 1'b0}. A read of 0x01 returns the current flag and then clears it.
- R3: The configuration registers sit at 0x03 direction, 0x05 output level, 0x07 tri-state, 0x09 expected level, 0x0B pull enable, 0x0D pull polarity and 0x11 mask. The input level is at 0x0F and the status at 0x13. A read strobe in cycle n places the data on rdata_o from cycle n+1, and the value holds until the next read. Unmapped addresses read 0x00 and ignore writes. Writes to 0x0F and 0x13 have no effect.
- R4: pad_out_o[i] equals output-level bit i while the pin is driven, and is 0 otherwise.
- R5: pad_oe_o[i] is 1 only when direction bit i is 1 and tri-state bit i is 0.
- R6: pull_en_o[i] is pull-enable bit i gated by direction bit i being 0 (input). pull_up_o[i] is polarity bit i, where 1 selects pull-up.
- R7: Each input passes through a two-stage synchronizer. A change on pad_in_i before edge k is visible in an input-level read issued in the cycle after edge k+1.
- R8: A status bit is set when the synchronized input differs from its expected bit and its mask bit is 0. A mask bit of 1 keeps that status bit from being set.
- R9: Status bits stay set until the status register is read. The read clears all of them. A bit whose condition still holds sets again on the following clock.
- R10: irq_no is low exactly while any status bit is set.
- R11: Writing 0x01 with bit 0 set restores every register and the status to its reset value and sets the reset-occurred flag. Bit 0 always reads 0. Writing 0x01 with bit 0 clear changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| re_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 8 | Registered read data |
| pad_in_i | input | 8 | Raw pin input levels |
| pad_oe_o | output | 8 | Per-pin output enable |
| pad_out_o | output | 8 | Per-pin driven level |
| pull_en_o | output | 8 | Per-pin pull resistor enable |
| pull_up_o | output | 8 | Per-pin pull polarity, 1 = up |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The hardest case is a status read that lands while the deviation that set the bit is still present. The read must clear the bit, and the bit must reappear one clock later. The stimulus holds a pin away from its expected level through two back-to-back status reads, then releases it and reads twice more, with the synchronizer delay counted in. A long random phase then overlaps reads and writes on the same address, fires software resets during reads of the identification register, and changes inputs under shifting masks. The behavioural model is compared against the design on every clock throughout.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int DW   = 8;
  localparam int AW   = 8;
  localparam int NCFG = 7;

  localparam int C_DIR = 0;
  localparam int C_OUT = 1;
  localparam int C_TRI = 2;
  localparam int C_EXP = 3;
  localparam int C_PEN = 4;
  localparam int C_PUP = 5;
  localparam int C_MSK = 6;

  localparam logic [AW-1:0] A_ID  = 8'h01;
  localparam logic [AW-1:0] A_LVL = 8'h0F;
  localparam logic [AW-1:0] A_STS = 8'h13;

  localparam logic [2:0] VENDOR_CODE = 3'b101;

  function automatic logic [AW-1:0] cfg_addr(input int i);
    case (i)
      C_DIR:   return 8'h03;
      C_OUT:   return 8'h05;
      C_TRI:   return 8'h07;
      C_EXP:   return 8'h09;
      C_PEN:   return 8'h0B;
      C_PUP:   return 8'h0D;
      default: return 8'h11;
    endcase
  endfunction

  function automatic logic [DW-1:0] cfg_rst(input int i);
    return (i == C_DIR || i == C_OUT) ? '0 : '1;
  endfunction

  function automatic logic is_mapped(input logic [AW-1:0] a);
    logic hit;
    hit = (a == A_ID) || (a == A_LVL) || (a == A_STS);
    for (int i = 0; i < NCFG; i++) if (a == cfg_addr(i)) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter logic [2:0] REV_ID = 3'd1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic                     we_i,
  input  logic                     re_i,
  input  logic [DW-1:0]            lvl_i,
  input  logic [DW-1:0]            sts_i,
  output logic [NCFG-1:0][DW-1:0]  cfg_o,
  output logic                     soft_rst_o,
  output logic                     sts_clr_o,
  output logic [DW-1:0]            rdata_o
);
  logic [DW-1:0] cfg_q [NCFG];
  logic          rst_flag_q;
  logic [DW-1:0] rd_val;
  logic [DW-1:0] rdata_q;
  logic          id_hit;

  assign id_hit     = (addr_i == A_ID);
  assign soft_rst_o = we_i && id_hit && wdata_i[0];
  assign sts_clr_o  = re_i && (addr_i == A_STS);

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               cfg_q[g] <= cfg_rst(g);
      else if (soft_rst_o)                       cfg_q[g] <= cfg_rst(g);
      else if (we_i && addr_i == cfg_addr(g))    cfg_q[g] <= wdata_i;
    end
    assign cfg_o[g] = cfg_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rst_flag_q <= 1'b1;
    else if (soft_rst_o)       rst_flag_q <= 1'b1;
    else if (re_i && id_hit)   rst_flag_q <= 1'b0;
  end

  always_comb begin
    rd_val = '0;
    if (id_hit)               rd_val = {VENDOR_CODE, REV_ID, rst_flag_q, 1'b0};
    else if (addr_i == A_LVL) rd_val = lvl_i;
    else if (addr_i == A_STS) rd_val = sts_i;
    else begin
      for (int i = 0; i < NCFG; i++)
        if (addr_i == cfg_addr(i)) rd_val = cfg_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  assert_unmapped_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !is_mapped(addr_i)) |=> (rdata_o == '0));

  assert_id_layout_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && id_hit && !we_i) |=> (rdata_o[7:5] == VENDOR_CODE && rdata_o[0] == 1'b0 && !rst_flag_q));

  assert_soft_reset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (rst_flag_q && cfg_q[C_DIR] == '0 && cfg_q[C_MSK] == '1));
endmodule

// File: rtl/gpx_pads.sv
module gpx_pads #(
  parameter int W = 8
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] out_i,
  input  logic [W-1:0] tri_i,
  input  logic [W-1:0] pen_i,
  input  logic [W-1:0] pup_i,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pull_en_o,
  output logic [W-1:0] pull_up_o
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    logic drive;
    assign drive        = dir_i[p] & ~tri_i[p];
    assign pad_oe_o[p]  = drive;
    assign pad_out_o[p] = out_i[p] & drive;
    assign pull_en_o[p] = pen_i[p] & ~dir_i[p];
    assign pull_up_o[p] = pup_i[p];
  end
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] exp_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  input  logic         soft_rst_i,
  output logic [W-1:0] sts_o,
  output logic         irq_no
);
  logic [W-1:0] sts_q;
  logic [W-1:0] hit;

  assign hit = (lvl_i ^ exp_i) & ~mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sts_q <= '0;
    else if (soft_rst_i || clr_i) sts_q <= '0;
    else                          sts_q <= sts_q | hit;
  end

  assign sts_o  = sts_q;
  assign irq_no = ~|sts_q;

  assert_read_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sts_q == '0));

  assert_masked_never_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~($past(lvl_i ^ exp_i) & ~$past(mask_i))) == '0));
endmodule

// File: rtl/gpio_expander_core.sv
module gpio_expander_core
  import gpx_pkg::*;
#(
  parameter logic [2:0] REV_ID      = 3'd1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          we_i,
  input  logic          re_i,
  output logic [7:0]    rdata_o,
  input  logic [7:0]    pad_in_i,
  output logic [7:0]    pad_oe_o,
  output logic [7:0]    pad_out_o,
  output logic [7:0]    pull_en_o,
  output logic [7:0]    pull_up_o,
  output logic          irq_no
);
  logic [NCFG-1:0][DW-1:0] cfg;
  logic [DW-1:0]           lvl;
  logic [DW-1:0]           sts;
  logic                    soft_rst;
  logic                    sts_clr;

  gpx_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (lvl)
  );

  gpx_regfile #(.REV_ID(REV_ID)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .we_i      (we_i),
    .re_i      (re_i),
    .lvl_i     (lvl),
    .sts_i     (sts),
    .cfg_o     (cfg),
    .soft_rst_o(soft_rst),
    .sts_clr_o (sts_clr),
    .rdata_o   (rdata_o)
  );

  gpx_pads #(.W(DW)) u_pads (
    .dir_i    (cfg[C_DIR]),
    .out_i    (cfg[C_OUT]),
    .tri_i    (cfg[C_TRI]),
    .pen_i    (cfg[C_PEN]),
    .pup_i    (cfg[C_PUP]),
    .pad_oe_o (pad_oe_o),
    .pad_out_o(pad_out_o),
    .pull_en_o(pull_en_o),
    .pull_up_o(pull_up_o)
  );

  gpx_irq #(.W(DW)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (lvl),
    .exp_i     (cfg[C_EXP]),
    .mask_i    (cfg[C_MSK]),
    .clr_i     (sts_clr),
    .soft_rst_i(soft_rst),
    .sts_o     (sts),
    .irq_no    (irq_no)
  );

  assert_pull_inputs_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_en_o & cfg[C_DIR]) == '0);

  assert_float_blocks_drive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & cfg[C_TRI]) == '0);

  assert_irq_tracks_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_clr && !soft_rst) |=> irq_no);
endmodule

// File: tb/gpio_expander_core_test.sv
`timescale 1ns/1ps
module gpio_expander_core_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr = '0, wdata = '0, pad_in = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] rdata, pad_oe, pad_out, pull_en, pull_up;
  logic       irq_n;

  always #2.5 clk = ~clk;

  gpio_expander_core #(.REV_ID(3'd1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .pad_in_i(pad_in),
    .pad_oe_o(pad_oe), .pad_out_o(pad_out), .pull_en_o(pull_en),
    .pull_up_o(pull_up), .irq_no(irq_n)
  );

  int    n_chk = 0, n_bad = 0, cyc = 0;
  bit    armed = 1'b0;
  string cur_tag = "R1";

  // behavioural reference
  logic [7:0] m_dir, m_out, m_tri, m_exp, m_pen, m_pup, m_msk, m_sts, m_rd;
  bit         m_flag;
  logic [7:0] m_sq[$];
  logic [7:0] m_lvl, m_hit, m_rv;
  bit         m_soft;

  function automatic logic [7:0] m_read(input logic [7:0] a);
    case (a)
      8'h01: return {3'b101, 3'd1, m_flag, 1'b0};
      8'h03: return m_dir;
      8'h05: return m_out;
      8'h07: return m_tri;
      8'h09: return m_exp;
      8'h0B: return m_pen;
      8'h0D: return m_pup;
      8'h0F: return m_sq[0];
      8'h11: return m_msk;
      8'h13: return m_sts;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_defaults();
    m_dir = 8'h00; m_out = 8'h00; m_tri = 8'hFF; m_exp = 8'hFF;
    m_pen = 8'hFF; m_pup = 8'hFF; m_msk = 8'hFF; m_flag = 1'b1; m_sts = 8'h00;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_defaults();
      m_rd = 8'h00;
      m_sq = '{8'h00, 8'h00};
    end else begin
      m_lvl  = m_sq[0];
      m_hit  = (m_lvl ^ m_exp) & ~m_msk;
      m_soft = we && addr == 8'h01 && wdata[0];
      if (re) begin
        m_rv = m_read(addr);
        m_rd = m_rv;
      end
      if (re && addr == 8'h13) m_sts = 8'h00;
      else                     m_sts = m_sts | m_hit;
      if (re && addr == 8'h01) m_flag = 1'b0;
      if (we) begin
        case (addr)
          8'h03: m_dir = wdata;
          8'h05: m_out = wdata;
          8'h07: m_tri = wdata;
          8'h09: m_exp = wdata;
          8'h0B: m_pen = wdata;
          8'h0D: m_pup = wdata;
          8'h11: m_msk = wdata;
          default: ;
        endcase
      end
      if (m_soft) m_defaults();
      m_sq.push_back(pad_in);
      void'(m_sq.pop_front());
    end
  end

  task automatic chk(input string what, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk("rdata",     cur_tag, rdata,   m_rd);
      chk("pad_out",   "R4",    pad_out, m_out & (m_dir & ~m_tri));
      chk("pad_oe",    "R5",    pad_oe,  m_dir & ~m_tri);
      chk("pull_en",   "R6",    pull_en, m_pen & ~m_dir);
      chk("pull_up",   "R6",    pull_up, m_pup);
      chk("irq_no",    "R10",   {7'b0, irq_n}, {7'b0, ~|m_sts});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected finish", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cur_tag = tag; addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
  endtask

  localparam logic [7:0] ADDRS [12] = '{8'h01, 8'h03, 8'h05, 8'h07, 8'h09, 8'h0B,
                                        8'h0D, 8'h0F, 8'h11, 8'h13, 8'h02, 8'h40};

  initial begin
    idle(3);
    armed = 1'b1;
    idle(1);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset values, R2 identification and flag clear
    rd(8'h03, "R1"); rd(8'h05, "R1"); rd(8'h07, "R1"); rd(8'h09, "R1");
    rd(8'h0B, "R1"); rd(8'h0D, "R1"); rd(8'h11, "R1"); rd(8'h13, "R1");
    rd(8'h01, "R2"); rd(8'h01, "R2");
    // R3 unmapped and read-only addresses
    wr(8'h02, 8'h55); wr(8'h40, 8'hAA); wr(8'h0F, 8'h12); wr(8'h13, 8'hFF);
    rd(8'h02, "R3"); rd(8'h40, "R3"); rd(8'h00, "R3"); rd(8'hFF, "R3");
    rd(8'h13, "R3"); rd(8'h0F, "R3");
    // R4 R5 drive and float
    wr(8'h03, 8'h0F); wr(8'h05, 8'hA5); idle(2);
    wr(8'h07, 8'h00); idle(2);
    wr(8'h07, 8'h05); idle(2);
    rd(8'h07, "R5");
    // R6 pulls
    wr(8'h0B, 8'h3C); wr(8'h0D, 8'h0F); idle(2);
    // R7 synchronizer latency
    pad_in = 8'h5A;
    rd(8'h0F, "R7"); rd(8'h0F, "R7"); rd(8'h0F, "R7"); idle(2); rd(8'h0F, "R7");
    // R8 deviation with mask open
    wr(8'h09, 8'h5A); wr(8'h11, 8'h00); idle(3);
    rd(8'h13, "R8");
    pad_in = 8'h5B; idle(4);
    rd(8'h13, "R8");
    // R9 persistent condition re-sets, sticky after release
    rd(8'h13, "R9"); rd(8'h13, "R9");
    pad_in = 8'h5A; idle(4);
    rd(8'h13, "R9"); idle(1); rd(8'h13, "R9");
    // R8 masked pin
    wr(8'h11, 8'h01); pad_in = 8'h5B; idle(4);
    rd(8'h13, "R8");
    pad_in = 8'hDB; idle(4);
    rd(8'h13, "R8"); rd(8'h13, "R8");
    // R11 software reset
    wr(8'h01, 8'hFE); rd(8'h03, "R11"); rd(8'h01, "R11");
    wr(8'h03, 8'hFF); wr(8'h07, 8'h00); idle(1);
    wr(8'h01, 8'h01); idle(1);
    rd(8'h03, "R11"); rd(8'h07, "R11"); rd(8'h09, "R11"); rd(8'h11, "R11");
    rd(8'h13, "R11"); rd(8'h01, "R11");
    // mixed random traffic
    cur_tag = "R3";
    for (int k = 0; k < 4000; k++) begin
      addr  = ADDRS[$urandom_range(0, 11)];
      wdata = 8'($urandom);
      we    = ($urandom_range(0, 3) == 0);
      re    = ($urandom_range(0, 2) == 0);
      if (addr == 8'h01 && $urandom_range(0, 15) != 0) wdata[0] = 1'b0;
      if ($urandom_range(0, 4) == 0) pad_in = 8'($urandom);
      @(negedge clk);
    end
    we = 1'b0; re = 1'b0;
    idle(4);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule